// File: doc/BRIEF.md
# Auto-Indexing Pointer and Program Counter Unit

This block holds the address-generation state of a small 8-bit processor core: two RAM data pointers, a stack pointer and a 15-bit program counter. Instruction decode tells it which pointer an access uses and whether that pointer should step forward, step back or stay put after the access. The unit then updates the pointer on the following clock edge, wrapping modulo 256.

The stack pointer starts at a fixed nonzero address. The unit supplies the RAM address for each push or pop, and moves the pointer so the stack grows downward. The program counter can be incremented, loaded with a branch target, or forced to the single interrupt vector. Its upper 7 bits and lower 8 bits are also presented separately.

The two data pointers and the stack pointer sit behind a small register port, so the core can read and write them as memory-mapped locations. The program counter is not reachable through this port. The reset input is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `addr_gen_unit`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, both data pointers and the program counter read zero and the stack pointer reads 0x6F.
- R2: An access strobe with mode 1 (increment) leaves the selected pointer one higher after the next clock edge, wrapping 0xFF to 0x00. The other pointer is unchanged.
- R3: An access strobe with mode 2 (decrement) leaves the selected pointer one lower after the next clock edge, wrapping 0x00 to 0xFF.
- R4: A pointer does not change when the strobe is low, or when the mode is 0 (no change) or 3 (reserved).
- R5: A register-port write to a pointer in the same cycle as that pointer's post-modify wins: the pointer takes the written value.
- R6: Register-port address 0 maps to pointer 0, address 1 to pointer 1 and address 2 to the stack pointer. A read returns the current value combinationally. Address 3 reads as 0x00, and writes to it have no effect.
- R7: A push presents the current stack pointer as the stack address and then decrements it. A pop presents the stack pointer plus one and then increments it. Push and pop together present the stack pointer and leave it unchanged. A register write to the stack pointer overrides push and pop.
- R8: Stack pointer arithmetic wraps modulo 256.
- R9: A PC increment adds one modulo 2^15. The upper-part output always equals PC bits 14:8 and the lower-part output equals PC bits 7:0.
- R10: A PC load puts the supplied 15-bit value into the program counter and takes priority over increment.
- R11: An interrupt request forces the program counter to 0x00FF, taking priority over load and increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Pointer access strobe |
| acc_sel | input | 1 | Pointer selected for the access |
| acc_mode | input | 2 | Post-modify mode: 0 none, 1 increment, 2 decrement, 3 reserved |
| ptr_addr | output | 2x8 | Current value of each data pointer |
| reg_wr | input | 1 | Register-port write strobe |
| reg_addr | input | 2 | Register-port address |
| reg_wdata | input | 8 | Register-port write data |
| reg_rdata | output | 8 | Register-port read data |
| stk_push | input | 1 | Stack push |
| stk_pop | input | 1 | Stack pop |
| stk_addr | output | 8 | RAM address for the stack access |
| sp_out | output | 8 | Current stack pointer |
| pc_load | input | 1 | Load the program counter |
| pc_load_val | input | 15 | Value to load |
| pc_inc | input | 1 | Increment the program counter |
| irq_vec | input | 1 | Interrupt vector request |
| pc_out | output | 15 | Program counter |
| pc_hi | output | 7 | Upper part of the program counter |
| pc_lo | output | 8 | Lower part of the program counter |

## Verification
The assertions assume that all control inputs are driven to known values in every cycle outside reset, and that the stimulus never leaves a strobe undefined. The bench meets this by starting every strobe at zero, changing inputs only on the falling clock edge, and returning the controls to idle after each operation. The properties also treat a push and a pop in the same cycle as a legal request that leaves the pointer unchanged. The bench drives that case on purpose, alongside the wrap-around cases at 0x00 and 0xFF and at the top of the PC range.

// File: rtl/agu_pkg.sv
package agu_pkg;
  // post-modify encodings for a pointer access
  localparam logic [1:0] PM_NONE = 2'd0;
  localparam logic [1:0] PM_INC  = 2'd1;
  localparam logic [1:0] PM_DEC  = 2'd2;

  localparam int unsigned DATA_W   = 8;
  localparam int unsigned PC_W     = 15;
  localparam int unsigned PC_LO_W  = 8;
endpackage

// File: rtl/agu_rst_sync.sv
module agu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

  // R1: internal reset stays low at least until the input has been high
  p_sync_release_r1: assert property (@(posedge clk)
    !rst_n |=> !rst_sync_n);
endmodule

// File: rtl/agu_ptr.sv
module agu_ptr
  import agu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_en,
  input  logic [1:0]   acc_mode,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] ptr_q;
  logic [W-1:0] ptr_d;
  logic         ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (wr_en) begin
      ptr_d  = wr_data;
      ptr_en = 1'b1;
    end else if (acc_en) begin
      case (acc_mode)
        PM_INC: begin ptr_d = ptr_q + W'(1); ptr_en = 1'b1; end
        PM_DEC: begin ptr_d = ptr_q - W'(1); ptr_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign q = ptr_q;

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_mode == PM_INC && !wr_en |=> q == W'($past(q) + W'(1)));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_mode == PM_DEC && !wr_en |=> q == W'($past(q) - W'(1)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && (!acc_en || acc_mode == PM_NONE || acc_mode == 2'd3) |=> $stable(q));
  p_wr_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_data));
endmodule

// File: rtl/agu_stack.sv
module agu_stack #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] SP_INIT = 8'h6F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] sp,
  output logic [W-1:0] stk_addr
);
  logic [W-1:0] sp_q;
  logic [W-1:0] sp_d;
  logic         sp_en;
  logic [W-1:0] sp_plus;
  logic [W-1:0] sp_minus;

  always_comb begin
    sp_plus  = sp_q + W'(1);
    sp_minus = sp_q - W'(1);
    sp_d     = sp_q;
    sp_en    = 1'b0;
    if (wr_en) begin
      sp_d  = wr_data;
      sp_en = 1'b1;
    end else if (push && !pop) begin
      sp_d  = sp_minus;
      sp_en = 1'b1;
    end else if (pop && !push) begin
      sp_d  = sp_plus;
      sp_en = 1'b1;
    end
  end

  always_comb begin
    stk_addr = (pop && !push) ? sp_plus : sp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_INIT;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

  p_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !wr_en |=> sp == W'($past(stk_addr) - W'(1)));
  p_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && !wr_en |=> sp == $past(stk_addr));
  p_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !wr_en |=> $stable(sp));
  p_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sp == $past(wr_data));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !wr_en && sp == '0 |=> sp == '1);
endmodule

// File: rtl/agu_pc.sv
module agu_pc #(
  parameter int unsigned   PC_W    = 15,
  parameter logic [PC_W-1:0] VECTOR = 15'h00FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq,
  input  logic            load,
  input  logic [PC_W-1:0] load_val,
  input  logic            inc,
  output logic [PC_W-1:0] pc
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic            pc_en;

  always_comb begin
    pc_d  = pc_q;
    pc_en = 1'b1;
    if (irq)       pc_d = VECTOR;
    else if (load) pc_d = load_val;
    else if (inc)  pc_d = pc_q + PC_W'(1);
    else           pc_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc = pc_q;

  p_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load && !irq |=> pc == PC_W'($past(pc) + PC_W'(1)));
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load && !irq |=> pc == $past(load_val));
  p_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> pc == VECTOR);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !load && !irq |=> $stable(pc));
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int unsigned W        = DATA_W,
  parameter int unsigned NUM_PTR  = 2,
  parameter int unsigned PCW      = PC_W,
  parameter int unsigned PCLW     = PC_LO_W,
  parameter logic [7:0]  SP_INIT  = 8'h6F,
  parameter logic [14:0] IRQ_ADDR = 15'h00FF,
  localparam int unsigned SEL_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
  localparam int unsigned REG_AW  = $clog2(NUM_PTR + 2),
  localparam int unsigned PCHW    = PCW - PCLW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_valid,
  input  logic [SEL_W-1:0]            acc_sel,
  input  logic [1:0]                  acc_mode,
  output logic [NUM_PTR-1:0][W-1:0]   ptr_addr,
  input  logic                        reg_wr,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [W-1:0]                reg_wdata,
  output logic [W-1:0]                reg_rdata,
  input  logic                        stk_push,
  input  logic                        stk_pop,
  output logic [W-1:0]                stk_addr,
  output logic [W-1:0]                sp_out,
  input  logic                        pc_load,
  input  logic [PCW-1:0]              pc_load_val,
  input  logic                        pc_inc,
  input  logic                        irq_vec,
  output logic [PCW-1:0]              pc_out,
  output logic [PCHW-1:0]             pc_hi,
  output logic [PCLW-1:0]             pc_lo
);
  logic                     rst_i_n;
  logic [NUM_PTR-1:0][W-1:0] ptr_q;
  logic [W-1:0]             sp_q;
  logic                     sp_wr;

  agu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic acc_hit;
    logic wr_hit;
    assign acc_hit = acc_valid && (acc_sel == SEL_W'(i));
    assign wr_hit  = reg_wr && (reg_addr == REG_AW'(i));
    agu_ptr #(.W(W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .acc_en   (acc_hit),
      .acc_mode (acc_mode),
      .wr_en    (wr_hit),
      .wr_data  (reg_wdata),
      .q        (ptr_q[i])
    );
  end

  assign sp_wr = reg_wr && (reg_addr == REG_AW'(NUM_PTR));

  agu_stack #(.W(W), .SP_INIT(SP_INIT[W-1:0])) u_stack (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .push     (stk_push),
    .pop      (stk_pop),
    .wr_en    (sp_wr),
    .wr_data  (reg_wdata),
    .sp       (sp_q),
    .stk_addr (stk_addr)
  );

  agu_pc #(.PC_W(PCW), .VECTOR(IRQ_ADDR[PCW-1:0])) u_pc (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .irq      (irq_vec),
    .load     (pc_load),
    .load_val (pc_load_val),
    .inc      (pc_inc),
    .pc       (pc_out)
  );

  // register-port read mux
  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_PTR; k++) begin
      if (reg_addr == REG_AW'(k)) reg_rdata = ptr_q[k];
    end
    if (reg_addr == REG_AW'(NUM_PTR)) reg_rdata = sp_q;
  end

  assign ptr_addr = ptr_q;
  assign sp_out   = sp_q;
  assign pc_hi    = pc_out[PCW-1:PCLW];
  assign pc_lo    = pc_out[PCLW-1:0];

  p_rd_sp_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    reg_addr == REG_AW'(NUM_PTR) |-> reg_rdata == sp_out);
  p_rd_p0_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    reg_addr == '0 |-> reg_rdata == ptr_addr[0]);
  p_split_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    {pc_hi, pc_lo} == pc_out);
  p_other_ptr_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    acc_valid && acc_sel == '0 && !(reg_wr && reg_addr == REG_AW'(1))
      |=> $stable(ptr_addr[1]));
endmodule

// File: tb/addr_gen_unit_test.sv
module addr_gen_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [0:0]  acc_sel;
  logic [1:0]  acc_mode;
  logic [1:0][7:0] ptr_addr;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        stk_push, stk_pop;
  logic [7:0]  stk_addr, sp_out;
  logic        pc_load, pc_inc, irq_vec;
  logic [14:0] pc_load_val, pc_out;
  logic [6:0]  pc_hi;
  logic [7:0]  pc_lo;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  addr_gen_unit uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel(acc_sel),
    .acc_mode(acc_mode), .ptr_addr(ptr_addr), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stk_push(stk_push), .stk_pop(stk_pop), .stk_addr(stk_addr),
    .sp_out(sp_out), .pc_load(pc_load), .pc_load_val(pc_load_val),
    .pc_inc(pc_inc), .irq_vec(irq_vec), .pc_out(pc_out), .pc_hi(pc_hi),
    .pc_lo(pc_lo)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] wa;
    logic [7:0] wd;
    logic       av;
    logic       as;
    logic [1:0] am;
    logic [7:0] e0;
    logic [7:0] e1;
    logic [7:0] esp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd1, 8'h01, 8'h00, 8'h6F}, // R2 inc p0
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd2, 8'h00, 8'h00, 8'h6F}, // R3 dec p0
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd2, 8'hFF, 8'h00, 8'h6F}, // R3 wrap low
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd1, 8'hFF, 8'h01, 8'h6F}, // R2 inc p1
    '{1'b1, 2'd1, 8'h80, 1'b1, 1'b1, 2'd1, 8'hFF, 8'h80, 8'h6F}, // R5 write beats inc
    '{1'b1, 2'd0, 8'h10, 1'b0, 1'b0, 2'd1, 8'h10, 8'h80, 8'h6F}, // R4 no strobe
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h10, 8'h80, 8'h6F}, // R4 mode none
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd3, 8'h10, 8'h80, 8'h6F}, // R4 reserved
    '{1'b1, 2'd3, 8'h55, 1'b1, 1'b1, 2'd3, 8'h10, 8'h80, 8'h6F}, // R6 addr 3 write
    '{1'b1, 2'd2, 8'hFF, 1'b0, 1'b0, 2'd0, 8'h10, 8'h80, 8'hFF}, // R6 sp write
    '{1'b1, 2'd0, 8'h20, 1'b1, 1'b1, 2'd1, 8'h20, 8'h81, 8'hFF}, // R5 other ptr
    '{1'b1, 2'd1, 8'h00, 1'b1, 1'b1, 2'd2, 8'h20, 8'h00, 8'hFF}, // R5 write beats dec
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd2, 8'h20, 8'hFF, 8'hFF}, // R3 wrap p1
    '{1'b1, 2'd0, 8'hFF, 1'b0, 1'b0, 2'd0, 8'hFF, 8'hFF, 8'hFF}  // R6 p0 write
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 1'b0; acc_sel = 1'b0; acc_mode = 2'd0;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    stk_push = 1'b0; stk_pop = 1'b0;
    pc_load = 1'b0; pc_inc = 1'b0; irq_vec = 1'b0; pc_load_val = 15'h0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    summary();
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (2) tick();
    // R1 state during reset
    chk("R1 p0 in reset", 32'(ptr_addr[0]), 32'h00);
    chk("R1 sp in reset", 32'(sp_out), 32'h6F);
    rst_n = 1'b1;
    // R1 first cycle after release: synchroniser still holds reset
    acc_valid = 1'b1; acc_mode = 2'd1; pc_inc = 1'b1;
    tick();
    chk("R1 p0 just after release", 32'(ptr_addr[0]), 32'h00);
    chk("R1 pc just after release", 32'(pc_out), 32'h0);
    idle();
    repeat (3) tick();
    chk("R1 p1 after release", 32'(ptr_addr[1]), 32'h00);
    chk("R1 sp after release", 32'(sp_out), 32'h6F);
    chk("R1 pc after release", 32'(pc_out), 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      reg_wr = VEC[i].wr; reg_addr = VEC[i].wa; reg_wdata = VEC[i].wd;
      acc_valid = VEC[i].av; acc_sel = VEC[i].as; acc_mode = VEC[i].am;
      tick();
      idle();
      chk($sformatf("R2-table p0 row %0d", i), 32'(ptr_addr[0]), 32'(VEC[i].e0));
      chk($sformatf("R3-table p1 row %0d", i), 32'(ptr_addr[1]), 32'(VEC[i].e1));
      chk($sformatf("R6-table sp row %0d", i), 32'(sp_out), 32'(VEC[i].esp));
    end

    // R2 wrap high: p0 = FF, increment
    acc_valid = 1'b1; acc_sel = 1'b0; acc_mode = 2'd1;
    tick(); idle();
    chk("R2 wrap high", 32'(ptr_addr[0]), 32'h00);

    // R6 reads
    reg_addr = 2'd0; #1 chk("R6 read p0", 32'(reg_rdata), 32'h00);
    reg_addr = 2'd1; #1 chk("R6 read p1", 32'(reg_rdata), 32'hFF);
    reg_addr = 2'd2; #1 chk("R6 read sp", 32'(reg_rdata), 32'hFF);
    reg_addr = 2'd3; #1 chk("R6 read addr3", 32'(reg_rdata), 32'h00);
    tick(); idle();

    // R7 push at FF
    stk_push = 1'b1; #1 chk("R7 push addr", 32'(stk_addr), 32'hFF);
    tick(); idle();
    chk("R7 push sp", 32'(sp_out), 32'hFE);
    stk_pop = 1'b1; #1 chk("R7 pop addr", 32'(stk_addr), 32'hFF);
    tick(); idle();
    chk("R7 pop sp", 32'(sp_out), 32'hFF);
    stk_pop = 1'b1; #1 chk("R8 pop addr wrap", 32'(stk_addr), 32'h00);
    tick(); idle();
    chk("R8 pop sp wrap", 32'(sp_out), 32'h00);
    stk_push = 1'b1; #1 chk("R8 push addr at zero", 32'(stk_addr), 32'h00);
    tick(); idle();
    chk("R8 push sp wrap", 32'(sp_out), 32'hFF);
    stk_push = 1'b1; stk_pop = 1'b1; #1 chk("R7 both addr", 32'(stk_addr), 32'hFF);
    tick(); idle();
    chk("R7 both sp", 32'(sp_out), 32'hFF);
    stk_push = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h30;
    tick(); idle();
    chk("R7 write beats push", 32'(sp_out), 32'h30);

    // PC
    pc_inc = 1'b1; tick(); idle();
    chk("R9 inc", 32'(pc_out), 32'h0001);
    pc_load = 1'b1; pc_load_val = 15'h7FFE; tick(); idle();
    chk("R10 load", 32'(pc_out), 32'h7FFE);
    chk("R9 hi", 32'(pc_hi), 32'h7F);
    chk("R9 lo", 32'(pc_lo), 32'hFE);
    pc_inc = 1'b1; tick(); tick(); idle();
    chk("R9 wrap", 32'(pc_out), 32'h0000);
    pc_load = 1'b1; pc_inc = 1'b1; pc_load_val = 15'h1234; tick(); idle();
    chk("R10 load over inc", 32'(pc_out), 32'h1234);
    chk("R9 hi split", 32'(pc_hi), 32'h12);
    irq_vec = 1'b1; pc_load = 1'b1; pc_inc = 1'b1; pc_load_val = 15'h0555;
    tick(); idle();
    chk("R11 vector", 32'(pc_out), 32'h00FF);
    chk("R11 lo", 32'(pc_lo), 32'hFF);
    tick();
    chk("R9 idle hold", 32'(pc_out), 32'h00FF);

    // R1 asynchronous reset mid-run
    #5 rst_n = 1'b0;
    #1;
    chk("R1 async sp", 32'(sp_out), 32'h6F);
    chk("R1 async pc", 32'(pc_out), 32'h0);
    chk("R1 async p1", 32'(ptr_addr[1]), 32'h00);
    tick();
    summary();
  end
endmodule